// File: doc/BRIEF.md
# Masked Condition-Field Logic Unit

This unit computes logic updates on a 32-bit condition register split into eight 4-bit fields. A request carries an operation code, the field or bit indices, an 8-bit truth-table immediate, a 4-bit write mask and the current register value. One clock edge later the unit presents the updated register, an illegal-request flag and a one-cycle done strobe.

Two operations work on whole fields. The field-ternary operation applies the immediate as a 3-input lookup table, bit by bit, over the destination field and two source fields. The field-binary operation uses a third field as a run-time 2-input lookup table over the destination and one source field. In both, a per-bit mask decides which destination bits are overwritten. An all-zero mask is rejected with the illegal flag. Two further operations update a single condition bit from three or two other bits. They use the immediate or a table field as the function and ignore the mask.

Top module: `cfl_unit`

## Requirements
- R1: Field n covers register bits 31-4n down to 28-4n, so field 0 is the most significant field. With req_op = 0 (field-ternary), each destination field bit at vector position k becomes tt_imm[{dst[k], a[k], b[k]}], with the destination bit as the index MSB.
- R2: With req_op = 1 (field-binary), each destination bit at position k becomes T[{dst[k], a[k]}], where T is the 4-bit value of field fld_b. Index 0 therefore selects the table field's least significant bit.
- R3: For field operations, wr_mask[k] gates the destination field bit at the same position k, so wr_mask[3] gates the field's most significant bit. A bit whose mask bit is 0 keeps its old value, and no bit outside the destination field changes.
- R4: A field operation with wr_mask = 0 sets illegal for that response and returns cr_out equal to cr_in.
- R5: With req_op = 2 (single-bit ternary), bit numbers count from the register MSB (bit b is vector position 31-b). Bit bit_dst becomes tt_imm[{c[bit_dst], c[bit_a], c[bit_b]}], and every other bit is unchanged.
- R6: With req_op = 3 (single-bit binary), bit bit_dst becomes T[{c[bit_dst], c[bit_a]}], where T is field fld_b as in R2, and every other bit is unchanged.
- R7: Single-bit operations ignore wr_mask and never set illegal, even when wr_mask = 0.
- R8: The result appears on the first clock edge after req_valid is sampled high. done is high for exactly one cycle per request, and cr_out holds while no request is presented.
- R9: While reset is asserted, cr_out is zero and done and illegal are low.
- R10: All sources are read from cr_in before any write. The destination may equal either source field or source bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 field-ternary, 1 field-binary, 2 bit-ternary, 3 bit-binary |
| fld_dst | input | 3 | Destination field index |
| fld_a | input | 3 | First source field index |
| fld_b | input | 3 | Second source field, or table field for binary operations |
| bit_dst | input | 5 | Destination bit number (MSB-first) |
| bit_a | input | 5 | First source bit number |
| bit_b | input | 5 | Second source bit number (ternary only) |
| tt_imm | input | 8 | Truth-table immediate |
| wr_mask | input | 4 | Per-bit write mask for field operations |
| cr_in | input | 32 | Current condition register value |
| cr_out | output | 32 | Updated condition register |
| illegal | output | 1 | Zero-mask field request flag, valid with done |
| done | output | 1 | One-cycle completion strobe |

## Verification
A wrong index order or a reversed table numbering shows up at cr_out as a wrong bit in the response cycle right after the request, so each vector is compared at that point. A mask decoded in the wrong order, or a write into the wrong field, leaves changed bits outside the allowed span in that same cycle. The illegal flag and the unchanged-register rule are checked in the same response. Stale output state shows up one idle cycle later as a non-zero done or a change in cr_out.

// File: rtl/cfl_pkg.sv
package cfl_pkg;

   typedef enum logic [1:0] {
      CFL_FTERN = 2'd0,
      CFL_FBIN  = 2'd1,
      CFL_BTERN = 2'd2,
      CFL_BBIN  = 2'd3
   } cfl_op_e;

   localparam int CFL_TERN_IDX_W = 3;
   localparam int CFL_BIN_IDX_W  = 2;
   localparam int CFL_IMM_W      = 1 << CFL_TERN_IDX_W;

endpackage

// File: rtl/cfl_lut.sv
module cfl_lut #(
   parameter int IDX_W   = 3,
   parameter bit LUT_SOP = 1'b0
) (
   input  logic [(1<<IDX_W)-1:0] tbl,
   input  logic [IDX_W-1:0]      idx,
   output logic                  val
);
   localparam int TBL_N = 1 << IDX_W;

   if (IDX_W < 1) begin : g_bad_idx
      $error("cfl_lut: IDX_W must be at least 1");
   end

   if (LUT_SOP) begin : g_sop
      // sum of products: one decoded minterm per table entry
      always_comb begin
         val = 1'b0;
         for (int e = 0; e < TBL_N; e++) begin
            val = val | ((idx == IDX_W'(e)) & tbl[e]);
         end
      end
   end else begin : g_mux
      assign val = tbl[idx];
   end
endmodule

// File: rtl/cfl_field_eval.sv
module cfl_field_eval #(
   parameter int FIELD_W = 4,
   parameter bit LUT_SOP = 1'b0
) (
   input  logic [FIELD_W-1:0]           dst,
   input  logic [FIELD_W-1:0]           srca,
   input  logic [FIELD_W-1:0]           srcb,
   input  logic [cfl_pkg::CFL_IMM_W-1:0] imm,
   input  logic [FIELD_W-1:0]           mask,
   input  logic                         is_bin,
   output logic [FIELD_W-1:0]           res
);
   import cfl_pkg::*;

   if (FIELD_W != (1 << CFL_BIN_IDX_W)) begin : g_bad_w
      $error("cfl_field_eval: FIELD_W must equal the binary table size");
   end

   for (genvar k = 0; k < FIELD_W; k++) begin : g_bit
      logic tern_v, bin_v, new_v;

      cfl_lut #(.IDX_W(CFL_TERN_IDX_W), .LUT_SOP(LUT_SOP)) u_tern (
         .tbl (imm),
         .idx ({dst[k], srca[k], srcb[k]}),
         .val (tern_v)
      );

      cfl_lut #(.IDX_W(CFL_BIN_IDX_W), .LUT_SOP(LUT_SOP)) u_bin (
         .tbl (srcb),
         .idx ({dst[k], srca[k]}),
         .val (bin_v)
      );

      assign new_v  = is_bin ? bin_v : tern_v;
      assign res[k] = mask[k] ? new_v : dst[k];

      // R3
      always_comb begin
         mask_keep_chk: assert (mask[k] || (res[k] == dst[k]));
      end
   end
endmodule

// File: rtl/cfl_bit_eval.sv
module cfl_bit_eval #(
   parameter int CR_W    = 32,
   parameter int FIELD_W = 4,
   parameter bit LUT_SOP = 1'b0,
   localparam int BIDX_W = $clog2(CR_W)
) (
   input  logic [CR_W-1:0]              cr,
   input  logic [BIDX_W-1:0]            bt,
   input  logic [BIDX_W-1:0]            ba,
   input  logic [BIDX_W-1:0]            bb,
   input  logic [FIELD_W-1:0]           tbl_fld,
   input  logic [cfl_pkg::CFL_IMM_W-1:0] imm,
   input  logic                         is_bin,
   output logic                         new_bit
);
   import cfl_pkg::*;

   localparam logic [BIDX_W-1:0] TOP = BIDX_W'(CR_W - 1);

   logic vt, va, vb, tern_v, bin_v;

   // bit numbers count from the register MSB
   assign vt = cr[TOP - bt];
   assign va = cr[TOP - ba];
   assign vb = cr[TOP - bb];

   cfl_lut #(.IDX_W(CFL_TERN_IDX_W), .LUT_SOP(LUT_SOP)) u_tern (
      .tbl (imm),
      .idx ({vt, va, vb}),
      .val (tern_v)
   );

   cfl_lut #(.IDX_W(CFL_BIN_IDX_W), .LUT_SOP(LUT_SOP)) u_bin (
      .tbl (tbl_fld),
      .idx ({vt, va}),
      .val (bin_v)
   );

   assign new_bit = is_bin ? bin_v : tern_v;
endmodule

// File: rtl/cfl_unit.sv
module cfl_unit #(
   parameter int NFIELDS = 8,
   parameter int FIELD_W = 4,
   parameter bit LUT_SOP = 1'b0,
   localparam int CR_W   = NFIELDS * FIELD_W,
   localparam int FIDX_W = $clog2(NFIELDS),
   localparam int BIDX_W = $clog2(CR_W)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req_valid,
   input  logic [1:0]                    req_op,
   input  logic [FIDX_W-1:0]             fld_dst,
   input  logic [FIDX_W-1:0]             fld_a,
   input  logic [FIDX_W-1:0]             fld_b,
   input  logic [BIDX_W-1:0]             bit_dst,
   input  logic [BIDX_W-1:0]             bit_a,
   input  logic [BIDX_W-1:0]             bit_b,
   input  logic [cfl_pkg::CFL_IMM_W-1:0]  tt_imm,
   input  logic [FIELD_W-1:0]            wr_mask,
   input  logic [CR_W-1:0]               cr_in,
   output logic [CR_W-1:0]               cr_out,
   output logic                          illegal,
   output logic                          done
);
   import cfl_pkg::*;

   if ((1 << FIDX_W) != NFIELDS) begin : g_bad_nf
      $error("cfl_unit: NFIELDS must be a power of two");
   end
   if ((1 << BIDX_W) != CR_W) begin : g_bad_cr
      $error("cfl_unit: register width must be a power of two");
   end

   cfl_op_e op;
   assign op = cfl_op_e'(req_op);

   logic is_field, is_bin, zero_mask;
   assign is_field  = (op == CFL_FTERN) || (op == CFL_FBIN);
   assign is_bin    = (op == CFL_FBIN) || (op == CFL_BBIN);
   assign zero_mask = is_field && (wr_mask == '0);

   // field extraction, field 0 at the register MSB
   logic [FIELD_W-1:0] f_dst, f_a, f_b, f_res;
   always_comb begin
      f_dst = '0;
      f_a   = '0;
      f_b   = '0;
      for (int n = 0; n < NFIELDS; n++) begin
         if (fld_dst == FIDX_W'(n)) f_dst = cr_in[CR_W-1-FIELD_W*n -: FIELD_W];
         if (fld_a   == FIDX_W'(n)) f_a   = cr_in[CR_W-1-FIELD_W*n -: FIELD_W];
         if (fld_b   == FIDX_W'(n)) f_b   = cr_in[CR_W-1-FIELD_W*n -: FIELD_W];
      end
   end

   cfl_field_eval #(.FIELD_W(FIELD_W), .LUT_SOP(LUT_SOP)) u_field (
      .dst    (f_dst),
      .srca   (f_a),
      .srcb   (f_b),
      .imm    (tt_imm),
      .mask   (wr_mask),
      .is_bin (is_bin),
      .res    (f_res)
   );

   logic nb;
   cfl_bit_eval #(.CR_W(CR_W), .FIELD_W(FIELD_W), .LUT_SOP(LUT_SOP)) u_bit (
      .cr      (cr_in),
      .bt      (bit_dst),
      .ba      (bit_a),
      .bb      (bit_b),
      .tbl_fld (f_b),
      .imm     (tt_imm),
      .is_bin  (is_bin),
      .new_bit (nb)
   );

   logic [CR_W-1:0] cr_fld, cr_bit, cr_nxt;
   always_comb begin
      cr_fld = cr_in;
      for (int n = 0; n < NFIELDS; n++) begin
         if (fld_dst == FIDX_W'(n)) cr_fld[CR_W-1-FIELD_W*n -: FIELD_W] = f_res;
      end
   end

   always_comb begin
      cr_bit = cr_in;
      cr_bit[BIDX_W'(CR_W-1) - bit_dst] = nb;
   end

   always_comb begin
      if (zero_mask)     cr_nxt = cr_in;
      else if (is_field) cr_nxt = cr_fld;
      else               cr_nxt = cr_bit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cr_out  <= '0;
         illegal <= 1'b0;
         done    <= 1'b0;
      end else begin
         done    <= req_valid;
         illegal <= req_valid && zero_mask;
         if (req_valid) cr_out <= cr_nxt;
      end
   end

   // span of bits a field request may change, built from the port fields
   logic [CR_W-1:0] span_chk;
   always_comb begin
      span_chk = '0;
      for (int n = 0; n < NFIELDS; n++) begin
         for (int k = 0; k < FIELD_W; k++) begin
            if ((fld_dst == FIDX_W'(n)) && wr_mask[k]) span_chk[CR_W-FIELD_W*(n+1)+k] = 1'b1;
         end
      end
   end

   // R8
   done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> done);
   // R8
   done_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!done && $stable(cr_out)));
   // R4
   zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_op[1] && (wr_mask == '0)) |=> (illegal && (cr_out == $past(cr_in))));
   // R7
   bit_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op[1]) |=> !illegal);
   // R5 R6
   one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op[1]) |=> ($countones(cr_out ^ $past(cr_in)) <= 1));
   // R3
   field_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_op[1]) |=> (((cr_out ^ $past(cr_in)) & ~$past(span_chk)) == '0));
   // R4
   illegal_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> done);
endmodule

// File: tb/tb_cfl_unit.sv
module tb_cfl_unit;

   typedef struct packed {
      logic [1:0]  op;
      logic [2:0]  fd, fa, fb;
      logic [4:0]  bt, ba, bb;
      logic [7:0]  imm;
      logic [3:0]  mask;
      logic [31:0] cr;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 3'd2, 3'd5, 3'd7, 5'd0,  5'd0,  5'd0,  8'hE8, 4'hF, 32'h1234_5678},
      '{2'd0, 3'd0, 3'd1, 3'd2, 5'd0,  5'd0,  5'd0,  8'h96, 4'hF, 32'hA5C3_0FF0},
      '{2'd0, 3'd7, 3'd0, 3'd3, 5'd0,  5'd0,  5'd0,  8'hCA, 4'hA, 32'hDEAD_BEEF},
      '{2'd0, 3'd4, 3'd4, 3'd4, 5'd0,  5'd0,  5'd0,  8'h01, 4'hF, 32'hFFFF_0000},
      '{2'd1, 3'd1, 3'd6, 3'd3, 5'd0,  5'd0,  5'd0,  8'h00, 4'hF, 32'h0F1E_2D3C},
      '{2'd1, 3'd6, 3'd2, 3'd5, 5'd0,  5'd0,  5'd0,  8'h00, 4'h6, 32'h9876_5432},
      '{2'd1, 3'd3, 3'd3, 3'd3, 5'd0,  5'd0,  5'd0,  8'h00, 4'hF, 32'h1357_9BDF},
      '{2'd2, 3'd0, 3'd0, 3'd0, 5'd0,  5'd31, 5'd15, 8'h7F, 4'h0, 32'h8000_0001},
      '{2'd2, 3'd0, 3'd0, 3'd0, 5'd31, 5'd0,  5'd31, 8'h0F, 4'h0, 32'h0000_0000},
      '{2'd3, 3'd0, 3'd0, 3'd7, 5'd10, 5'd20, 5'd0,  8'h00, 4'h0, 32'hC0DE_F00D},
      '{2'd3, 3'd0, 3'd0, 3'd1, 5'd5,  5'd5,  5'd0,  8'h00, 4'h3, 32'h0240_0000},
      '{2'd0, 3'd3, 3'd1, 3'd2, 5'd0,  5'd0,  5'd0,  8'hFF, 4'h0, 32'h0000_0000},
      '{2'd1, 3'd5, 3'd6, 3'd7, 5'd0,  5'd0,  5'd0,  8'h00, 4'h0, 32'hFFFF_FFFF}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_op = '0;
   logic [2:0]  fld_dst = '0, fld_a = '0, fld_b = '0;
   logic [4:0]  bit_dst = '0, bit_a = '0, bit_b = '0;
   logic [7:0]  tt_imm = '0;
   logic [3:0]  wr_mask = '0;
   logic [31:0] cr_in = '0;
   logic [31:0] cr_out;
   logic        illegal, done;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   cfl_unit dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .fld_dst(fld_dst), .fld_a(fld_a), .fld_b(fld_b),
      .bit_dst(bit_dst), .bit_a(bit_a), .bit_b(bit_b),
      .tt_imm(tt_imm), .wr_mask(wr_mask), .cr_in(cr_in),
      .cr_out(cr_out), .illegal(illegal), .done(done)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // reference from the requirements, MSB-first bit numbering
   function automatic logic [31:0] model(input vec_t v, output logic ill);
      logic [31:0] r;
      int idx;
      r   = v.cr;
      ill = 1'b0;
      if (v.op < 2'd2) begin
         if (v.mask == 4'h0) begin
            ill = 1'b1;
            return v.cr;
         end
         for (int i = 0; i < 4; i++) begin
            int kd, ka, kb;
            logic nv;
            kd = 4*int'(v.fd) + i;
            ka = 4*int'(v.fa) + i;
            kb = 4*int'(v.fb) + i;
            if (v.op == 2'd0) begin
               idx = 4*int'(v.cr[31-kd]) + 2*int'(v.cr[31-ka]) + int'(v.cr[31-kb]);
               nv  = v.imm[idx];
            end else begin
               idx = 2*int'(v.cr[31-kd]) + int'(v.cr[31-ka]);
               nv  = v.cr[31-(4*int'(v.fb) + 3 - idx)];
            end
            if (v.mask[3-i]) r[31-kd] = nv;
         end
      end else if (v.op == 2'd2) begin
         idx = 4*int'(v.cr[31-int'(v.bt)]) + 2*int'(v.cr[31-int'(v.ba)]) + int'(v.cr[31-int'(v.bb)]);
         r[31-int'(v.bt)] = v.imm[idx];
      end else begin
         idx = 2*int'(v.cr[31-int'(v.bt)]) + int'(v.cr[31-int'(v.ba)]);
         r[31-int'(v.bt)] = v.cr[31-(4*int'(v.fb) + 3 - idx)];
      end
      return r;
   endfunction

   function automatic string tag(input vec_t v);
      if (v.op < 2'd2 && v.mask == 4'h0) return "R4";
      case (v.op)
         2'd0:    return (v.fd == v.fa) ? "R1/R10" : "R1/R3";
         2'd1:    return (v.fd == v.fa) ? "R2/R10" : "R2/R3";
         2'd2:    return "R5/R7";
         default: return (v.bt == v.ba) ? "R6/R10" : "R6";
      endcase
   endfunction

   task automatic apply(input vec_t v);
      @(negedge clk);
      req_valid = 1'b1;
      req_op = v.op; fld_dst = v.fd; fld_a = v.fa; fld_b = v.fb;
      bit_dst = v.bt; bit_a = v.ba; bit_b = v.bb;
      tt_imm = v.imm; wr_mask = v.mask; cr_in = v.cr;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset values
      check("R9 cr_out", cr_out, 32'h0);
      check("R9 done", {31'b0, done}, 32'h0);
      check("R9 illegal", {31'b0, illegal}, 32'h0);
      rst_n = 1'b1;

      for (int n = 0; n < NV; n++) begin
         logic [31:0] exp;
         logic ill;
         exp = model(VECS[n], ill);
         apply(VECS[n]);
         check(tag(VECS[n]), cr_out, exp);
         check("R4/R7 illegal", {31'b0, illegal}, {31'b0, ill});
         check("R8 done", {31'b0, done}, 32'h1);
      end

      // R8 idle: done drops, output holds
      begin
         logic [31:0] held;
         held = cr_out;
         cr_in = 32'h5555_AAAA;
         tt_imm = 8'hFF;
         @(negedge clk);
         check("R8 done one cycle", {31'b0, done}, 32'h0);
         check("R8 illegal cleared", {31'b0, illegal}, 32'h0);
         @(negedge clk);
         check("R8 hold", cr_out, held);
      end

      // R3 single mask bit: only the field MSB of field 0 may change
      apply('{2'd0, 3'd0, 3'd1, 3'd2, 5'd0, 5'd0, 5'd0, 8'hFF, 4'h8, 32'h0000_0000});
      check("R3 single mask", cr_out, 32'h8000_0000);

      // R7 bit op with zero mask still writes
      apply('{2'd2, 3'd0, 3'd0, 3'd0, 5'd3, 5'd4, 5'd5, 8'h01, 4'h0, 32'h0000_0000});
      check("R7 write", cr_out, 32'h1000_0000);
      check("R7 legal", {31'b0, illegal}, 32'h0);

      // R2 table index 0 selects the table field LSB
      apply('{2'd1, 3'd0, 3'd1, 3'd2, 5'd0, 5'd0, 5'd0, 8'h00, 4'hF, 32'h0010_0000});
      check("R2 lsb entry", cr_out, 32'hF010_0000);

      // R9 reset mid-run clears outputs
      rst_n = 1'b0;
      @(negedge clk);
      check("R9 re-reset", cr_out, 32'h0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule